// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the hazard-control logic for a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. It looks at the register numbers held in the four pipeline registers. From them it picks the source for each of the two ALU operands, choosing between the register file, the execute/memory latch and the memory/writeback latch. It also detects a load whose result is needed by the instruction right behind it. When that happens it freezes the program counter and the fetch/decode latch, and it zeroes the control bits entering the decode/execute latch, so that a nop goes down the pipe in place of the held instruction.

The outputs are combinational and follow the inputs within the same cycle. A parameter removes the bypass paths. In that build a load-use stall lasts two cycles, so the dependent instruction reads the loaded value from the register file after writeback. A single flop provides the second cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: When the execute/memory write enable is 1 and its destination is nonzero and equals the decode/execute source A (or B), the select for that operand is 2'b10.
- R2: When there is no R1 match for an operand, a matching, nonzero and write-enabled memory/writeback destination gives select 2'b01. When neither latch matches, the select is 2'b00 (register file).
- R3: When both latches match the same operand, the execute/memory latch wins and the select is 2'b10.
- R4: Register 0 never produces a forward select or a stall.
- R5: A destination whose write enable is 0 never forwards, even when its register number matches.
- R6: A load-use hazard raises `pc_hold_o`, `ifid_hold_o` and `bubble_o` in the same cycle as the inputs. The hazard is: `idex_mem_rd_i`=1, `idex_rt_i` nonzero, and `idex_rt_i` equal to `ifid_rs_i` or to `ifid_rt_i`. If `idex_mem_rd_i` is 0, there is no stall.
- R7: With forwarding enabled, a load-use stall lasts exactly one cycle. Once the hazard inputs are gone, all three stall outputs are 0.
- R8: With forwarding disabled, both operand selects are always 2'b00.
- R9: With forwarding disabled, a load-use stall that starts from an idle state is held for one more cycle even after the hazard inputs are gone. It ends in the cycle after that.
- R10: Reset (active low, asynchronous) clears the stall extension, so no stall appears unless a hazard is present on the inputs.
- R11: `pc_hold_o`, `ifid_hold_o` and `bubble_o` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the stall-extension flop |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ifid_rs_i | input | 5 | Source A register of the instruction in decode |
| ifid_rt_i | input | 5 | Source B register of the instruction in decode |
| idex_rs_i | input | 5 | Source A register of the instruction in execute |
| idex_rt_i | input | 5 | Source B / load destination in execute |
| idex_mem_rd_i | input | 1 | Instruction in execute is a load |
| exmem_rd_i | input | 5 | Destination register in the memory stage |
| exmem_reg_wr_i | input | 1 | Memory-stage instruction writes a register |
| memwb_rd_i | input | 5 | Destination register in writeback |
| memwb_reg_wr_i | input | 1 | Writeback instruction writes a register |
| fwd_a_o | output | 2 | Operand A source: 00 regfile, 10 exe/mem, 01 mem/wb |
| fwd_b_o | output | 2 | Operand B source, same encoding |
| pc_hold_o | output | 1 | Freeze the program counter |
| ifid_hold_o | output | 1 | Freeze the fetch/decode latch |
| bubble_o | output | 1 | Zero control bits entering decode/execute |

## Verification
The bench targets the case where both latches match one operand. A design with the priority reversed would feed the ALU a stale value. It also drives register 0 as a load destination and as a forward source: a design that forgot the zero guard would stall or forward for nothing. A load whose destination matches only the decode B field is tested too, which catches a comparator that checks only source A. In the build without bypass, the bench removes the hazard after the first stall cycle and checks that the stall still lasts two cycles. A missing extension would release the dependent instruction before writeback, and one that never clears would hang fetch.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF   = 2'b00,
    FWD_WB   = 2'b01,
    FWD_MEM  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hazard_fwd_sel.sv
module hazard_fwd_sel
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic              exmem_wr_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic              memwb_wr_i,
  output fwd_sel_e          sel_o
);
  logic src_live, hit_mem, hit_wb;

  assign src_live = |src_i;
  assign hit_mem  = src_live && exmem_wr_i && (exmem_rd_i == src_i);
  assign hit_wb   = src_live && memwb_wr_i && (memwb_rd_i == src_i);

  // newer result wins
  always_comb begin
    if (hit_mem)     sel_o = FWD_MEM;
    else if (hit_wb) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end
endmodule

// File: rtl/hazard_load_use.sv
module hazard_load_use #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ifid_rs_i,
  input  logic [REG_AW-1:0] ifid_rt_i,
  input  logic [REG_AW-1:0] idex_rt_i,
  input  logic              idex_mem_rd_i,
  output logic              hit_o
);
  logic dst_live;

  assign dst_live = |idex_rt_i;
  assign hit_o    = idex_mem_rd_i && dst_live &&
                    ((idex_rt_i == ifid_rs_i) || (idex_rt_i == ifid_rt_i));
endmodule

// File: rtl/hazard_stall_ext.sv
module hazard_stall_ext #(
  parameter bit FWD_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic stall_o
);
  localparam bit NEED_EXT = !FWD_EN;

  logic ext_q, ext_d;

  // second cycle only when no bypass path exists
  assign ext_d   = NEED_EXT && hit_i && !ext_q;
  assign stall_o = hit_i || ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_d;
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter bit FWD_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] ifid_rs_i,
  input  logic [REG_AW-1:0] ifid_rt_i,
  input  logic [REG_AW-1:0] idex_rs_i,
  input  logic [REG_AW-1:0] idex_rt_i,
  input  logic              idex_mem_rd_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic              exmem_reg_wr_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic              memwb_reg_wr_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              pc_hold_o,
  output logic              ifid_hold_o,
  output logic              bubble_o
);
  localparam int N_OPS = 2;

  logic [REG_AW-1:0] op_src [N_OPS];
  logic [1:0]        op_sel [N_OPS];
  logic              lu_hit, stall;

  assign op_src[0] = idex_rs_i;
  assign op_src[1] = idex_rt_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    if (FWD_EN) begin : g_fwd
      fwd_sel_e sel;
      hazard_fwd_sel #(.REG_AW(REG_AW)) u_sel (
        .src_i      (op_src[g]),
        .exmem_rd_i (exmem_rd_i),
        .exmem_wr_i (exmem_reg_wr_i),
        .memwb_rd_i (memwb_rd_i),
        .memwb_wr_i (memwb_reg_wr_i),
        .sel_o      (sel)
      );
      assign op_sel[g] = sel;
    end else begin : g_nofwd
      assign op_sel[g] = FWD_RF;
    end
  end

  hazard_load_use #(.REG_AW(REG_AW)) u_lu (
    .ifid_rs_i     (ifid_rs_i),
    .ifid_rt_i     (ifid_rt_i),
    .idex_rt_i     (idex_rt_i),
    .idex_mem_rd_i (idex_mem_rd_i),
    .hit_o         (lu_hit)
  );

  hazard_stall_ext #(.FWD_EN(FWD_EN)) u_ext (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (lu_hit),
    .stall_o (stall)
  );

  assign fwd_a_o     = op_sel[0];
  assign fwd_b_o     = op_sel[1];
  assign pc_hold_o   = stall;
  assign ifid_hold_o = stall;
  assign bubble_o    = stall;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_AW = 5,
  parameter bit FWD_EN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] ifid_rs_i,
  input logic [REG_AW-1:0] ifid_rt_i,
  input logic [REG_AW-1:0] idex_rs_i,
  input logic [REG_AW-1:0] idex_rt_i,
  input logic              idex_mem_rd_i,
  input logic [REG_AW-1:0] exmem_rd_i,
  input logic              exmem_reg_wr_i,
  input logic [REG_AW-1:0] memwb_rd_i,
  input logic              memwb_reg_wr_i,
  input logic [1:0]        fwd_a_o,
  input logic [1:0]        fwd_b_o,
  input logic              pc_hold_o,
  input logic              ifid_hold_o,
  input logic              bubble_o
);
  logic lu, mem_a, wb_a, prev_bub_q;

  assign lu    = idex_mem_rd_i && (idex_rt_i != '0) &&
                 (idex_rt_i == ifid_rs_i || idex_rt_i == ifid_rt_i);
  assign mem_a = exmem_reg_wr_i && (exmem_rd_i != '0) && (exmem_rd_i == idex_rs_i);
  assign wb_a  = memwb_reg_wr_i && (memwb_rd_i != '0) && (memwb_rd_i == idex_rs_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_bub_q <= 1'b0;
    else         prev_bub_q <= bubble_o;
  end

  a_r11_hold_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_hold_o == bubble_o) && (ifid_hold_o == bubble_o));

  a_r6_load_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lu |-> bubble_o);

  a_r3_mem_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (FWD_EN && mem_a && wb_a) |-> (fwd_a_o == 2'b10));

  a_r4_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idex_rs_i == '0) |-> (fwd_a_o == 2'b00));

  a_r7_single_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (FWD_EN && !lu) |-> !bubble_o);

  a_r9_second_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!FWD_EN && lu && !prev_bub_q) |=> bubble_o);
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_AW(REG_AW), .FWD_EN(FWD_EN)) chk_i (.*);

// File: tb/hazard_ctrl_tb_top.sv
module hazard_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  typedef struct packed {
    logic [4:0] if_rs;
    logic [4:0] if_rt;
    logic [4:0] ex_rs;
    logic [4:0] ex_rt;
    logic       ld;
    logic [4:0] m_rd;
    logic       m_wr;
    logic [4:0] w_rd;
    logic       w_wr;
    logic [1:0] ea;
    logic [1:0] eb;
    logic       es;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0}, // R2 idle
    '{5'd0, 5'd0, 5'd3, 5'd4, 1'b0, 5'd3, 1'b1, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0}, // R1 A
    '{5'd0, 5'd0, 5'd7, 5'd4, 1'b0, 5'd4, 1'b1, 5'd0, 1'b0, 2'b00, 2'b10, 1'b0}, // R1 B
    '{5'd0, 5'd0, 5'd7, 5'd4, 1'b0, 5'd0, 1'b0, 5'd7, 1'b1, 2'b01, 2'b00, 1'b0}, // R2
    '{5'd0, 5'd0, 5'd5, 5'd5, 1'b0, 5'd5, 1'b1, 5'd5, 1'b1, 2'b10, 2'b10, 1'b0}, // R3
    '{5'd0, 5'd0, 5'd5, 5'd8, 1'b0, 5'd5, 1'b0, 5'd5, 1'b1, 2'b01, 2'b00, 1'b0}, // R5
    '{5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0}, // R4
    '{5'd6, 5'd2, 5'd1, 5'd6, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1}, // R6 rs
    '{5'd2, 5'd6, 5'd1, 5'd6, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1}, // R6 rt
    '{5'd0, 5'd3, 5'd1, 5'd0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0}, // R4 load r0
    '{5'd6, 5'd6, 5'd1, 5'd6, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0}, // R6 no load
    '{5'd0, 5'd0, 5'd9, 5'd2, 1'b0, 5'd2, 1'b1, 5'd9, 1'b1, 2'b01, 2'b10, 1'b0}  // R2 mixed
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] if_rs = '0, if_rt = '0, ex_rs = '0, ex_rt = '0, m_rd = '0, w_rd = '0;
  logic ld = 1'b0, m_wr = 1'b0, w_wr = 1'b0;
  logic [1:0] fa, fb, nfa, nfb;
  logic pch, ifh, bub, npch, nifh, nbub;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_ctrl #(.REG_AW(AW), .FWD_EN(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ifid_rs_i(if_rs), .ifid_rt_i(if_rt),
    .idex_rs_i(ex_rs), .idex_rt_i(ex_rt), .idex_mem_rd_i(ld),
    .exmem_rd_i(m_rd), .exmem_reg_wr_i(m_wr), .memwb_rd_i(w_rd), .memwb_reg_wr_i(w_wr),
    .fwd_a_o(fa), .fwd_b_o(fb), .pc_hold_o(pch), .ifid_hold_o(ifh), .bubble_o(bub));

  hazard_ctrl #(.REG_AW(AW), .FWD_EN(1'b0)) dut_nf_i (
    .clk_i(clk), .rst_ni(rst_n), .ifid_rs_i(if_rs), .ifid_rt_i(if_rt),
    .idex_rs_i(ex_rs), .idex_rt_i(ex_rt), .idex_mem_rd_i(ld),
    .exmem_rd_i(m_rd), .exmem_reg_wr_i(m_wr), .memwb_rd_i(w_rd), .memwb_reg_wr_i(w_wr),
    .fwd_a_o(nfa), .fwd_b_o(nfb), .pc_hold_o(npch), .ifid_hold_o(nifh), .bubble_o(nbub));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    if_rs = v.if_rs; if_rt = v.if_rt; ex_rs = v.ex_rs; ex_rt = v.ex_rt; ld = v.ld;
    m_rd = v.m_rd; m_wr = v.m_wr; w_rd = v.w_rd; w_wr = v.w_wr;
  endtask

  task automatic idle();
    drive('0);
  endtask

  task automatic load_use();
    idle();
    if_rs = 5'd6; ex_rt = 5'd6; ld = 1'b1;
  endtask

  initial begin
    // R10 reset state
    @(negedge clk); #1;
    chk("R10 fwd stall in reset", {3'b0, bub}, 4'h0);
    chk("R10 nofwd stall in reset", {3'b0, nbub}, 4'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); drive(VECS[i]); #1;
      chk($sformatf("R1/R2/R3/R4/R5/R6 vec%0d fwd", i), {fa, fb}, {VECS[i].ea, VECS[i].eb});
      chk($sformatf("R6 vec%0d stall", i), {3'b0, bub}, {3'b0, VECS[i].es});
      chk($sformatf("R11 vec%0d holds", i), {2'b0, pch, ifh}, {2'b0, bub, bub});
      chk($sformatf("R8 vec%0d nofwd sel", i), {nfa, nfb}, 4'h0);
    end

    // clear any extension left in the no-forward build
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R7 / R9: single load-use cycle, then hazard removed
    @(negedge clk); load_use(); #1;
    chk("R6 fwd stall first", {3'b0, bub}, 4'h1);
    chk("R9 nofwd stall first", {3'b0, nbub}, 4'h1);
    @(negedge clk); idle(); #1;
    chk("R7 fwd stall released", {3'b0, bub}, 4'h0);
    chk("R9 nofwd stall second", {3'b0, nbub}, 4'h1);
    chk("R11 nofwd holds second", {2'b0, npch, nifh}, 4'h3);
    @(negedge clk); #1;
    chk("R9 nofwd stall released", {3'b0, nbub}, 4'h0);
    @(negedge clk); #1;
    chk("R9 nofwd stays idle", {3'b0, nbub}, 4'h0);

    // R10: reset clears a pending extension
    @(negedge clk); load_use();
    @(negedge clk); idle(); rst_n = 1'b0; #1;
    chk("R10 reset clears extension", {3'b0, nbub}, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 idle after reset", {2'b0, npch, bub}, 4'h0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule